// File: doc/BRIEF.md
# Active-First Video Timing Generator

This block produces the raster timing for a display from the pixel clock. Every line and every frame is counted from its first visible pixel: the active region comes first, then front porch, sync pulse and back porch. Each region boundary is an absolute counter value, not a width, so the sync position is set by two thresholds on the same counter that measures the active area.

The horizontal counter advances on every enabled clock. The vertical counter advances once per line, when the horizontal counter wraps. Four thresholds per axis set the timing: active end, sync start, sync end and total. They are taken into internal copies only at the end of a frame, or at any time while the block is idle, so a running frame always uses one consistent set. All outputs come from one register stage and describe the same pixel: the two syncs, a combined display-enable flag, the pixel coordinates, and single-cycle start-of-frame and end-of-line markers.

Top module: `vid_timing_gen`

## Requirements
- R1: While enabled, the horizontal coordinate `px_x` counts 0, 1, ... up to `h_total`-1 and then returns to 0, one step per clock.
- R2: On an active line, the display enable is high exactly for `px_x` below `h_act_end`, so the line starts with its active pixels.
- R3: `hsync` is asserted for `h_sync_beg` <= `px_x` < `h_sync_end` and deasserted elsewhere. With the default polarity parameter, asserted means low (0).
- R4: `px_y` advances by one when `px_x` wraps, returns to 0 after `v_total`-1, and `vsync` is asserted for `v_sync_beg` <= `px_y` < `v_sync_end` (low by default).
- R5: `de` is high only when `px_x` < `h_act_end` and `px_y` < `v_act_end` both hold.
- R6: `sof` is high for exactly the one clock in which (`px_x`, `px_y`) = (0, 0).
- R7: `eol` is high for exactly the one clock in which `px_x` = `h_act_end`-1 on a line with `px_y` < `v_act_end`.
- R8: Threshold inputs take effect only from the next frame start. A change made mid-frame leaves the current frame's length and regions unchanged. While the block is idle, the inputs are taken directly.
- R9: While `rst_n` is low or `en` is low, the outputs show `px_x` = `px_y` = 0, `de`, `sof` and `eol` low, and both syncs deasserted. The first clock after `en` rises shows pixel (0, 0) with `sof` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low holds the raster at its origin |
| h_act_end | input | CW | First horizontal count after the active pixels |
| h_sync_beg | input | CW | Horizontal count at which sync asserts |
| h_sync_end | input | CW | Horizontal count at which sync deasserts |
| h_total | input | CW | Clocks per line |
| v_act_end | input | CW | First line count after the active lines |
| v_sync_beg | input | CW | Line count at which vertical sync asserts |
| v_sync_end | input | CW | Line count at which vertical sync deasserts |
| v_total | input | CW | Lines per frame |
| hsync | output | 1 | Horizontal sync, polarity set by parameter |
| vsync | output | 1 | Vertical sync, polarity set by parameter |
| de | output | 1 | Display enable, high on visible pixels |
| px_x | output | CW | Horizontal coordinate of the current pixel |
| px_y | output | CW | Vertical coordinate of the current pixel |
| sof | output | 1 | One-clock marker at pixel (0, 0) |
| eol | output | 1 | One-clock marker at the last visible pixel of a visible line |

## Verification
The bench builds the block with its default parameters: a 12-bit counter width and active-low syncs on both axes. It then programs small thresholds (16 by 8 and 12 by 6 rasters), so that every pixel of several complete frames is compared with coordinates and flags that the bench computes from the cycle count. At this size the bench can also reach the rare events: a threshold change in the middle of a frame, a drop of enable in the middle of a frame, and a restart that loads new thresholds while idle.

// File: rtl/vtg_pkg.sv
// Package: shared constants for the video timing generator.
// Holds the field indices of the packed threshold vector and the
// recommended default timing (800x400 visible within 1056x420).
package vtg_pkg;

    // Field order inside one axis group of the packed threshold vector
    localparam int unsigned F_ACT   = 0;
    localparam int unsigned F_SBEG  = 1;
    localparam int unsigned F_SEND  = 2;
    localparam int unsigned F_TOT   = 3;
    localparam int unsigned NFIELD  = 4;
    localparam int unsigned NAXIS   = 2;

    // Recommended default timing, in pixels and lines
    localparam int unsigned DEF_H_ACT  = 800;
    localparam int unsigned DEF_H_SBEG = 840;
    localparam int unsigned DEF_H_SEND = 968;
    localparam int unsigned DEF_H_TOT  = 1056;
    localparam int unsigned DEF_V_ACT  = 400;
    localparam int unsigned DEF_V_SBEG = 401;
    localparam int unsigned DEF_V_SEND = 404;
    localparam int unsigned DEF_V_TOT  = 420;

    // Decoded region flags of one axis
    typedef struct packed {
        logic act;
        logic sync;
        logic last_act;
    } axis_flags_t;

endpackage

// File: rtl/vtg_shadow.sv
// Module: vtg_shadow
// Holds the working copy of the timing thresholds. It copies its input
// whenever load is high or reset is asserted, and otherwise holds.
// Assumes the caller raises load only at a frame boundary or while idle.
module vtg_shadow #(
    parameter int unsigned W = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Copy the thresholds at a safe point and hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            q <= d;
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R8

endmodule

// File: rtl/vtg_axis_cnt.sv
// Module: vtg_axis_cnt
// One raster axis counter. It counts from 0 to last on each step and
// then wraps. It is held at 0 while reset is asserted or run is low.
// Assumes last is at least 0 (a total of at least 1 is programmed).
module vtg_axis_cnt #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] last,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    // The counter is about to return to 0 on this step
    assign wrap = step && (cnt == last);

    // Advance, wrap or hold the position on this axis
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == last) ? '0 : cnt + CW'(1);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last); // R1

    AST_CNT_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap) |=> (cnt == '0)); // R1

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(cnt)); // R4

endmodule

// File: rtl/vtg_axis_decode.sv
// Module: vtg_axis_decode
// Combinational region decode for one axis. The active region is
// [0, act_end), the sync region is [sync_beg, sync_end), and last_act
// marks count act_end-1. Assumes act_end is at least 1.
module vtg_axis_decode
    import vtg_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] act_end,
    input  logic [CW-1:0] sync_beg,
    input  logic [CW-1:0] sync_end,
    output axis_flags_t   flags
);

    // Compare the count against the absolute thresholds
    always_comb begin
        flags.act      = (cnt < act_end);
        flags.sync     = (cnt >= sync_beg) && (cnt < sync_end);
        flags.last_act = (cnt == act_end - CW'(1));
    end

endmodule

// File: rtl/vid_timing_gen.sv
// Module: vid_timing_gen (top)
// Raster timing generator whose counters start at the first visible
// pixel. Both axes share one counter and decode structure, built in a
// generate loop. The thresholds are held in a working copy that is
// refreshed at the end of a frame or while idle. One register stage
// aligns every output to the same pixel.
// Assumes 1 <= act_end <= total and sync_beg <= sync_end <= total per axis.
module vid_timing_gen
    import vtg_pkg::*;
#(
    parameter int unsigned CW          = 12,
    parameter bit          HS_ACT_HIGH = 1'b0,
    parameter bit          VS_ACT_HIGH = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] h_act_end,
    input  logic [CW-1:0] h_sync_beg,
    input  logic [CW-1:0] h_sync_end,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_act_end,
    input  logic [CW-1:0] v_sync_beg,
    input  logic [CW-1:0] v_sync_end,
    input  logic [CW-1:0] v_total,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] px_x,
    output logic [CW-1:0] px_y,
    output logic          sof,
    output logic          eol
);

    localparam int unsigned TW      = NAXIS * NFIELD * CW;
    localparam logic        HS_IDLE = ~HS_ACT_HIGH;
    localparam logic        VS_IDLE = ~VS_ACT_HIGH;

    logic [TW-1:0] thr_d;
    logic [TW-1:0] thr_q;
    logic [CW-1:0] cnt   [NAXIS];
    logic          wrap  [NAXIS];
    logic          step  [NAXIS];
    axis_flags_t   flg   [NAXIS];
    logic          frame_end;
    logic          reload;

    // Pack the threshold inputs: axis 0 horizontal, axis 1 vertical
    assign thr_d = {v_total, v_sync_end, v_sync_beg, v_act_end,
                    h_total, h_sync_end, h_sync_beg, h_act_end};

    // The vertical axis steps when the line wraps; the frame ends when it wraps
    assign step[0]   = 1'b1;
    assign step[1]   = wrap[0];
    assign frame_end = wrap[1];
    assign reload    = !en || frame_end;

    vtg_shadow #(.W(TW)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reload),
        .d     (thr_d),
        .q     (thr_q)
    );

    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
        localparam int unsigned BASE = a * NFIELD * CW;

        logic [CW-1:0] last_cnt;

        // Highest count of this axis under the working thresholds
        assign last_cnt = thr_q[BASE + F_TOT*CW +: CW] - CW'(1);

        vtg_axis_cnt #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (en),
            .step  (step[a]),
            .last  (last_cnt),
            .cnt   (cnt[a]),
            .wrap  (wrap[a])
        );

        vtg_axis_decode #(.CW(CW)) u_dec (
            .cnt      (cnt[a]),
            .act_end  (thr_q[BASE + F_ACT*CW  +: CW]),
            .sync_beg (thr_q[BASE + F_SBEG*CW +: CW]),
            .sync_end (thr_q[BASE + F_SEND*CW +: CW]),
            .flags    (flg[a])
        );
    end

    // Register the decoded pixel, forcing the idle picture when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hsync <= HS_IDLE;
            vsync <= VS_IDLE;
            de    <= 1'b0;
            sof   <= 1'b0;
            eol   <= 1'b0;
            px_x  <= '0;
            px_y  <= '0;
        end else begin
            hsync <= flg[0].sync ? ~HS_IDLE : HS_IDLE;
            vsync <= flg[1].sync ? ~VS_IDLE : VS_IDLE;
            de    <= flg[0].act && flg[1].act;
            sof   <= (cnt[0] == '0) && (cnt[1] == '0);
            eol   <= flg[0].last_act && flg[1].act;
            px_x  <= cnt[0];
            px_y  <= cnt[1];
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!de && !sof && !eol && px_x == '0 && px_y == '0
                 && hsync == HS_IDLE && vsync == VS_IDLE)); // R9

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (px_x == '0 || px_x == $past(px_x) + CW'(1))); // R1

    AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (px_x == '0 && px_y == '0)); // R6

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && en) |=> !sof); // R6

    AST_EOL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        eol |-> de); // R7

    AST_EOL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eol |=> !eol); // R7

endmodule

// File: tb/sim_vid_timing_gen.sv
// Bench: sweeps every pixel of small rasters and compares all outputs
// with values computed from the cycle position.
module sim_vid_timing_gen;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] h_act_end, h_sync_beg, h_sync_end, h_total;
    logic [CW-1:0] v_act_end, v_sync_beg, v_sync_end, v_total;
    logic          hsync, vsync, de, sof, eol;
    logic [CW-1:0] px_x, px_y;

    int total = 0;
    int bad   = 0;
    int cur [8];
    int mx = 0;
    int my = 0;

    always #4 clk = ~clk;

    vid_timing_gen #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .h_act_end(h_act_end), .h_sync_beg(h_sync_beg),
        .h_sync_end(h_sync_end), .h_total(h_total),
        .v_act_end(v_act_end), .v_sync_beg(v_sync_beg),
        .v_sync_end(v_sync_end), .v_total(v_total),
        .hsync(hsync), .vsync(vsync), .de(de),
        .px_x(px_x), .px_y(px_y), .sof(sof), .eol(eol)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic drive_cfg(input int ha, input int hb, input int he, input int ht,
                             input int va, input int vb, input int ve, input int vt);
        h_act_end = CW'(ha); h_sync_beg = CW'(hb); h_sync_end = CW'(he); h_total = CW'(ht);
        v_act_end = CW'(va); v_sync_beg = CW'(vb); v_sync_end = CW'(ve); v_total = CW'(vt);
    endtask

    task automatic take_cfg();
        cur[0] = int'(h_act_end); cur[1] = int'(h_sync_beg);
        cur[2] = int'(h_sync_end); cur[3] = int'(h_total);
        cur[4] = int'(v_act_end); cur[5] = int'(v_sync_beg);
        cur[6] = int'(v_sync_end); cur[7] = int'(v_total);
    endtask

    // Compare the current outputs with the expected pixel (mx, my)
    task automatic check_pixel();
        bit vis_line = (my < cur[4]);
        chk("R1 x", int'(px_x), mx);
        chk("R4 y", int'(px_y), my);
        chk("R2 R5 de", int'(de), int'(vis_line && mx < cur[0]));
        chk("R3 hsync", int'(hsync), (mx >= cur[1] && mx < cur[2]) ? 0 : 1);
        chk("R4 vsync", int'(vsync), (my >= cur[5] && my < cur[6]) ? 0 : 1);
        chk("R6 sof", int'(sof), int'(mx == 0 && my == 0));
        chk("R7 eol", int'(eol), int'(vis_line && mx == cur[0] - 1));
    endtask

    // Move the expected position one pixel on; new thresholds at frame end (R8)
    task automatic advance();
        if (mx == cur[3] - 1) begin
            mx = 0;
            if (my == cur[7] - 1) begin
                my = 0;
                take_cfg();
            end else begin
                my++;
            end
        end else begin
            mx++;
        end
    endtask

    task automatic check_idle(input string req);
        chk({req, " idle x"}, int'(px_x), 0);
        chk({req, " idle y"}, int'(px_y), 0);
        chk({req, " idle de"}, int'(de), 0);
        chk({req, " idle sof"}, int'(sof), 0);
        chk({req, " idle eol"}, int'(eol), 0);
        chk({req, " idle hsync"}, int'(hsync), 1);
        chk({req, " idle vsync"}, int'(vsync), 1);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL R1 watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int sof_at;
        // Configuration A: 16 x 8 raster, 8 x 4 visible
        drive_cfg(8, 10, 13, 16, 4, 5, 6, 8);
        repeat (3) @(negedge clk);
        check_idle("R9 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R9 disabled");

        // Three full frames of A
        take_cfg();
        mx = 0; my = 0;
        en = 1'b1;
        for (int k = 0; k < 3 * 128; k++) begin
            @(negedge clk);
            check_pixel();
            advance();
        end

        // Mid-frame change to B (12 x 6, 6 x 3 visible); frame A must finish (R8)
        sof_at = -1;
        for (int k = 0; k < 128 + 3 * 72; k++) begin
            @(negedge clk);
            check_pixel();
            if (k > 0 && sof && sof_at < 0) sof_at = k;
            advance();
            if (k == 40) drive_cfg(6, 7, 9, 12, 3, 4, 5, 6);
        end
        chk("R8 old frame length kept", sof_at, 128);

        // Drop enable mid-frame, change back to A while idle, restart (R9, R8)
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check_pixel();
            advance();
        end
        en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check_idle("R9 dropped");
            if (k == 2) drive_cfg(8, 10, 13, 16, 4, 5, 6, 8);
        end
        take_cfg();
        mx = 0; my = 0;
        en = 1'b1;
        @(negedge clk);
        chk("R9 restart sof", int'(sof), 1);
        check_pixel();
        advance();
        for (int k = 1; k < 2 * 128; k++) begin
            @(negedge clk);
            check_pixel();
            advance();
        end

        // Synchronous reset while running returns to the idle picture (R9)
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R9 reset run");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule